// File: doc/BRIEF.md
# Linear CCD Readout Timing Sequencer

This block drives a linear CCD sensor and paces the converter that digitises its output. It generates the pixel shift clock and the readout gate pulse, both from the system clock through count parameters. For every pixel it also raises a one-cycle strobe for an external ADC, together with the pixel's position in the line and a class tag. A line consists of a leading dummy run with an optical-black window inside it, then the effective pixels, then a trailing dummy run. The leading run is one pixel longer when the sensor's internal sample-and-hold is in use.

A line is requested either by a one-cycle `start` or by holding `free_run` high. Each line begins with a guard interval, then the gate pulse, then a second guard interval. After that comes a fixed number of 50 % duty shift-clock periods. The shift clock stays low while the gate is active and during both guard intervals. After reset, lines are not flagged valid until the sensor has received a set number of warm-up shift pulses.

Top module: `ccd_line_seq`

## Requirements
- R1: During reset and after reset with no request, `sclk`, `rog`, `adc_strobe`, `line_start`, `line_end` and `line_valid` are all low, and they stay low while neither `start` nor `free_run` is high.
- R2: The readout gate `rog` is high for exactly GATE_CYC consecutive cycles per line, and `sclk` is low in every one of those cycles.
- R3: The first `sclk` high cycle of a line follows the last `rog` high cycle after exactly POST_CYC cycles with `rog` and `sclk` both low.
- R4: Between the last `sclk` falling edge of a line and the next `rog` rise there are at least PRE_CYC cycles.
- R5: Each shift-clock period is HALF_DIV cycles high followed by HALF_DIV cycles low.
- R6: Every line carries exactly LINE_PULSES shift-clock periods. `line_start` is high for one cycle, in the first `sclk` high cycle of the line. `line_end` is high for one cycle, in the cycle after the low half of the last period.
- R7: `adc_strobe` is high for exactly one cycle per shift period, STROBE_CYC cycles after the cycle in which `sclk` rises. At that cycle `pix_index` equals the 0-based position of the pixel in the line.
- R8: With `sh_mode`=0 (no sample-and-hold), `pix_class` at the strobe is 0 (leading dummy) for indices 0..11 and 30..31, and 1 (optical black) for indices 12..29. It is 2 (effective) for indices 32..32+EFF_PIX-1 and 3 (trailing dummy) for all later indices.
- R9: With `sh_mode`=1 (sample-and-hold), the leading run is 33 pixels. Class 1 covers indices 13..30, class 0 covers the other indices below 33, class 2 starts at index 33, and class 3 follows the effective run.
- R10: `line_valid` is high from the `line_start` cycle through the last low cycle of a line only if WARMUP_PULSES shift pulses had been issued since reset before that line began. It is low otherwise and outside lines. Reset re-arms the warm-up.
- R11: While `free_run` is high, the next line's guard interval begins in the `line_end` cycle, so `rog` rises exactly PRE_CYC cycles after `line_end`. When no request is present at the end of a line, the block goes idle and issues no further pulses.
- R12: `sh_mode` is captured when the line's shift phase begins. A change of `sh_mode` during a line has no effect on that line's `pix_class` values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, enters warm-up |
| start | input | 1 | One-shot line request |
| free_run | input | 1 | Continuous line request while high |
| sh_mode | input | 1 | 1 = sample-and-hold mode (33-pixel leading run) |
| sclk | output | 1 | Pixel shift clock to the sensor |
| rog | output | 1 | Readout gate pulse to the sensor |
| adc_strobe | output | 1 | One-cycle conversion strobe per pixel |
| pix_class | output | 2 | 0 leading dummy, 1 optical black, 2 effective, 3 trailing dummy |
| pix_index | output | 12 | 0-based pixel position within the line |
| line_start | output | 1 | Pulse in the first shift-clock high cycle of a line |
| line_end | output | 1 | Pulse after the final shift period |
| line_valid | output | 1 | High during lines that began after warm-up |

## Verification
The hardest boundary to reach is the warm-up threshold. It only matters when it falls at a line start, because validity is decided once per line. The bench sets the warm-up count to exactly two lines' worth of pulses and runs free-running lines from reset. It expects the first two lines to be flagged invalid and the third to be flagged valid. A later reset followed by a single line shows that the threshold is re-armed. A mode change in the middle of a line is produced by a parallel thread that flips `sh_mode` partway through the shift phase while the line is being checked pixel by pixel.

// File: rtl/ccd_seq_pkg.sv
`timescale 1ns/1ps
package ccd_seq_pkg;

  typedef enum logic [1:0] {
    PC_LEAD  = 2'd0,
    PC_OB    = 2'd1,
    PC_EFF   = 2'd2,
    PC_TRAIL = 2'd3
  } pix_class_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_GATE,
    ST_POST,
    ST_SHIFT
  } seq_state_e;

endpackage

// File: rtl/ccd_pix_classifier.sv
`timescale 1ns/1ps
module ccd_pix_classifier
  import ccd_seq_pkg::*;
#(
  parameter int IDX_W    = 12,
  parameter int LEAD_PIX = 32,
  parameter int OB_PIX   = 18,
  parameter int OB_TAIL  = 2,
  parameter int EFF_PIX  = 2048
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             mode_sh,
  output pix_class_e       cls_q,
  output logic [IDX_W-1:0] idx_q
);

  logic [31:0] idx_w;
  logic [31:0] lead;
  logic [31:0] ob_lo;
  logic [31:0] ob_hi;
  pix_class_e  cls_d;

  assign idx_w = {{(32-IDX_W){1'b0}}, idx};
  assign lead  = 32'(LEAD_PIX) + {31'd0, mode_sh};
  assign ob_lo = lead - 32'(OB_TAIL) - 32'(OB_PIX);
  assign ob_hi = lead - 32'(OB_TAIL) - 32'd1;

  always_comb begin
    if (idx_w < lead) begin
      cls_d = (idx_w >= ob_lo && idx_w <= ob_hi) ? PC_OB : PC_LEAD;
    end else if (idx_w < lead + 32'(EFF_PIX)) begin
      cls_d = PC_EFF;
    end else begin
      cls_d = PC_TRAIL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_q <= PC_LEAD;
      idx_q <= '0;
    end else begin
      cls_q <= cls_d;
      idx_q <= idx;
    end
  end

  AST_EFF_NEEDS_LEAD: assert property (@(posedge clk) disable iff (rst)
    (cls_q == PC_EFF) |-> (idx_q >= IDX_W'(LEAD_PIX))) else $error("eff before lead");  // R8

endmodule

// File: rtl/ccd_strobe_delay.sv
`timescale 1ns/1ps
module ccd_strobe_delay #(
  parameter int DLY = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  output logic strobe
);

  logic [DLY-1:0] pipe;

  generate
    if (DLY == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= rise;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[DLY-2:0], rise};
      end
    end
  endgenerate

  assign strobe = pipe[DLY-1];

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe) else $error("strobe longer than one cycle");  // R7

endmodule

// File: rtl/ccd_warmup.sv
`timescale 1ns/1ps
module ccd_warmup #(
  parameter int WARMUP_PULSES = 22500
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse,
  output logic warm
);

  localparam int CNT_W = $clog2(WARMUP_PULSES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WARMUP_PULSES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      warm <= 1'b0;
    end else if (pulse && !warm) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) warm <= 1'b1;
    end
  end

  AST_WARM_STICKY: assert property (@(posedge clk) disable iff (rst)
    warm |=> warm) else $error("warm dropped");  // R10

endmodule

// File: rtl/ccd_line_seq.sv
`timescale 1ns/1ps
module ccd_line_seq
  import ccd_seq_pkg::*;
#(
  parameter int HALF_DIV      = 25,
  parameter int GATE_CYC      = 500,
  parameter int PRE_CYC       = 300,
  parameter int POST_CYC      = 300,
  parameter int STROBE_CYC    = 30,
  parameter int LINE_PULSES   = 2088,
  parameter int WARMUP_PULSES = 22500,
  parameter int LEAD_PIX      = 32,
  parameter int OB_PIX        = 18,
  parameter int OB_TAIL       = 2,
  parameter int EFF_PIX       = 2048,
  parameter int IDX_W         = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             free_run,
  input  logic             sh_mode,
  output logic             sclk,
  output logic             rog,
  output logic             adc_strobe,
  output logic [1:0]       pix_class,
  output logic [IDX_W-1:0] pix_index,
  output logic             line_start,
  output logic             line_end,
  output logic             line_valid
);

  localparam int TMAX0 = (PRE_CYC > GATE_CYC) ? PRE_CYC : GATE_CYC;
  localparam int TMAX  = (POST_CYC > TMAX0) ? POST_CYC : TMAX0;
  localparam int TMR_W = $clog2(TMAX + 1);
  localparam int PH_W  = $clog2(HALF_DIV + 1);
  localparam logic [TMR_W-1:0] PRE_LOAD  = TMR_W'(PRE_CYC - 1);
  localparam logic [TMR_W-1:0] GATE_LOAD = TMR_W'(GATE_CYC - 1);
  localparam logic [TMR_W-1:0] POST_LOAD = TMR_W'(POST_CYC - 1);
  localparam logic [PH_W-1:0]  PH_LOAD   = PH_W'(HALF_DIV - 1);
  localparam logic [IDX_W-1:0] LAST_PIX  = IDX_W'(LINE_PULSES - 1);

  seq_state_e       st;
  logic [TMR_W-1:0] tmr;
  logic [PH_W-1:0]  ph;
  logic             hi;
  logic [IDX_W-1:0] pix;
  logic             mode_q;
  logic             rise_q;
  logic             warm;
  logic             req;
  pix_class_e       cls_q;

  assign req = start | free_run;

  always_ff @(posedge clk) begin
    line_start <= 1'b0;
    line_end   <= 1'b0;
    rise_q     <= 1'b0;
    if (rst) begin
      st         <= ST_IDLE;
      tmr        <= '0;
      ph         <= '0;
      hi         <= 1'b0;
      pix        <= '0;
      mode_q     <= 1'b0;
      sclk       <= 1'b0;
      rog        <= 1'b0;
      line_valid <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req) begin
            st  <= ST_PRE;
            tmr <= PRE_LOAD;
          end
        end
        ST_PRE: begin
          if (tmr == '0) begin
            st  <= ST_GATE;
            rog <= 1'b1;
            tmr <= GATE_LOAD;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_GATE: begin
          if (tmr == '0) begin
            st  <= ST_POST;
            rog <= 1'b0;
            tmr <= POST_LOAD;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_POST: begin
          if (tmr == '0) begin
            st         <= ST_SHIFT;
            sclk       <= 1'b1;
            hi         <= 1'b1;
            ph         <= PH_LOAD;
            pix        <= '0;
            rise_q     <= 1'b1;
            line_start <= 1'b1;
            line_valid <= warm;
            mode_q     <= sh_mode;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_SHIFT: begin
          if (ph != '0) begin
            ph <= ph - 1'b1;
          end else if (hi) begin
            hi   <= 1'b0;
            sclk <= 1'b0;
            ph   <= PH_LOAD;
          end else if (pix == LAST_PIX) begin
            line_end   <= 1'b1;
            line_valid <= 1'b0;
            if (req) begin
              st  <= ST_PRE;
              tmr <= PRE_LOAD;
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            pix    <= pix + 1'b1;
            sclk   <= 1'b1;
            hi     <= 1'b1;
            ph     <= PH_LOAD;
            rise_q <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  ccd_pix_classifier #(
    .IDX_W(IDX_W), .LEAD_PIX(LEAD_PIX), .OB_PIX(OB_PIX),
    .OB_TAIL(OB_TAIL), .EFF_PIX(EFF_PIX)
  ) u_cls (
    .clk(clk), .rst(rst), .idx(pix), .mode_sh(mode_q),
    .cls_q(cls_q), .idx_q(pix_index)
  );

  assign pix_class = cls_q;

  ccd_strobe_delay #(.DLY(STROBE_CYC)) u_strb (
    .clk(clk), .rst(rst), .rise(rise_q), .strobe(adc_strobe)
  );

  ccd_warmup #(.WARMUP_PULSES(WARMUP_PULSES)) u_warm (
    .clk(clk), .rst(rst), .pulse(rise_q), .warm(warm)
  );

  // checker-side counters, independent of the sequencing state
  logic [TMR_W:0] gate_run;
  logic [IDX_W:0] pulses;
  logic           seen_line;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_run  <= '0;
      pulses    <= '0;
      seen_line <= 1'b0;
    end else begin
      gate_run <= rog ? gate_run + 1'b1 : '0;
      if (rog) pulses <= '0;
      else if (sclk && !hi) pulses <= pulses;
      else if (rise_q) pulses <= pulses + 1'b1;
      if (line_end) seen_line <= 1'b1;
    end
  end

  AST_SCLK_LOW_IN_GATE: assert property (@(posedge clk) disable iff (rst)
    rog |-> !sclk) else $error("sclk active in gate");  // R2

  AST_GATE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(rog) |-> (gate_run == (TMR_W+1)'(GATE_CYC))) else $error("gate width");  // R2

  AST_LINE_PULSES: assert property (@(posedge clk) disable iff (rst)
    ($rose(rog) && seen_line) |-> (pulses == (IDX_W+1)'(LINE_PULSES))) else $error("pulse count");  // R6

  AST_START_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    line_start |-> $rose(sclk)) else $error("line_start misplaced");  // R6

  AST_VALID_NEEDS_WARM: assert property (@(posedge clk) disable iff (rst)
    line_valid |-> warm) else $error("valid before warm-up");  // R10

endmodule

// File: tb/tb_ccd_line_seq.sv
`timescale 1ns/1ps
module tb_ccd_line_seq;

  localparam int H    = 2;
  localparam int GATE = 6;
  localparam int PRE  = 3;
  localparam int POST = 4;
  localparam int D    = 3;
  localparam int LINE = 56;
  localparam int WARM = 112;
  localparam int EFF  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic free_run = 1'b0;
  logic sh_mode = 1'b0;
  logic sclk, rog, adc_strobe, line_start, line_end, line_valid;
  logic [1:0]  pix_class;
  logic [11:0] pix_index;

  int errors = 0;
  int checks = 0;
  int since_fall = 1000000;
  int last_wait = 0;
  logic prev_sclk = 1'b0;

  always #5 clk = ~clk;

  ccd_line_seq #(
    .HALF_DIV(H), .GATE_CYC(GATE), .PRE_CYC(PRE), .POST_CYC(POST),
    .STROBE_CYC(D), .LINE_PULSES(LINE), .WARMUP_PULSES(WARM), .EFF_PIX(EFF)
  ) dut (
    .clk(clk), .rst(rst), .start(start), .free_run(free_run), .sh_mode(sh_mode),
    .sclk(sclk), .rog(rog), .adc_strobe(adc_strobe), .pix_class(pix_class),
    .pix_index(pix_index), .line_start(line_start), .line_end(line_end),
    .line_valid(line_valid)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (prev_sclk && !sclk) since_fall = 0;
    else since_fall++;
    prev_sclk = sclk;
  endtask

  function automatic int exp_class(input int p, input bit m);
    int lead = 32 + int'(m);
    if (p < lead) return (p >= lead - 20 && p <= lead - 3) ? 1 : 0;
    if (p < lead + EFF) return 2;
    return 3;
  endfunction

  task automatic pulse_start();
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic measure_line(input bit m, input bit exp_valid, input string cls_req);
    int n = 0;
    int w = 0;
    int quiet_err = 0;
    int g = 0;
    int wave_err = 0, strb_err = 0, cls_err = 0, idx_err = 0, val_err = 0, nstrb = 0;
    while (!rog && n < 5000) begin
      step();
      n++;
    end
    last_wait = n;
    chk(since_fall >= PRE, "R4", "cycles from last sclk fall to gate", since_fall, PRE);
    while (rog && w < 5000) begin
      if (sclk) quiet_err++;
      w++;
      step();
    end
    chk(w == GATE, "R2", "gate width", w, GATE);
    chk(quiet_err == 0, "R2", "sclk high cycles in gate", quiet_err, 0);
    while (!sclk && g < 5000) begin
      g++;
      step();
    end
    chk(g == POST, "R3", "gate-to-clock guard", g, POST);
    chk(line_start == 1'b1, "R6", "line_start at first rise", int'(line_start), 1);
    for (int p = 0; p < LINE; p++) begin
      for (int k = 0; k < 2*H; k++) begin
        if (sclk !== (k < H)) wave_err++;
        if (line_end) wave_err++;
        if (adc_strobe !== (k == D)) strb_err++;
        if (adc_strobe) begin
          nstrb++;
          if (int'(pix_index) != p) idx_err++;
          if (int'(pix_class) != exp_class(p, m)) cls_err++;
        end
        if (line_valid !== exp_valid) val_err++;
        step();
      end
    end
    chk(wave_err == 0, "R5", "shift clock waveform mismatches", wave_err, 0);
    chk(line_end == 1'b1 && sclk == 1'b0, "R6", "line_end after last period", int'(line_end), 1);
    chk(strb_err == 0 && nstrb == LINE, "R7", "strobe count", nstrb, LINE);
    chk(idx_err == 0, "R7", "pix_index mismatches", idx_err, 0);
    chk(cls_err == 0, cls_req, "pix_class mismatches", cls_err, 0);
    chk(val_err == 0, "R10", "line_valid mismatches in line", val_err, 0);
    chk(line_valid == 1'b0, "R10", "line_valid after line", int'(line_valid), 0);
  endtask

  task automatic do_reset();
    int act = 0;
    rst = 1'b1;
    start = 1'b0;
    free_run = 1'b0;
    repeat (3) step();
    chk({sclk, rog, adc_strobe, line_start, line_end, line_valid} == 6'b0,
        "R1", "outputs during reset", int'({sclk, rog, adc_strobe, line_start, line_end, line_valid}), 0);
    rst = 1'b0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (sclk || rog || adc_strobe || line_start || line_end || line_valid) act++;
    end
    chk(act == 0, "R1", "active cycles without request", act, 0);
  endtask

  task automatic test_warmup_freerun();
    sh_mode = 1'b0;
    free_run = 1'b1;
    measure_line(1'b0, 1'b0, "R8");
    measure_line(1'b0, 1'b0, "R8");
    chk(last_wait == PRE, "R11", "free-run gap line_end to gate", last_wait, PRE);
    fork
      measure_line(1'b0, 1'b1, "R8");
      begin
        repeat (60) @(negedge clk);
        free_run = 1'b0;
      end
    join
    chk(last_wait == PRE, "R11", "free-run gap before third line", last_wait, PRE);
  endtask

  task automatic test_idle_after_line();
    int act = 0;
    for (int i = 0; i < 60; i++) begin
      step();
      if (sclk || rog || adc_strobe) act++;
    end
    chk(act == 0, "R11", "activity after line without request", act, 0);
  endtask

  task automatic test_sh_mode_line();
    sh_mode = 1'b1;
    pulse_start();
    measure_line(1'b1, 1'b1, "R9");
  endtask

  task automatic test_mode_change_ignored();
    sh_mode = 1'b0;
    pulse_start();
    fork
      measure_line(1'b0, 1'b1, "R12");
      begin
        repeat (100) @(negedge clk);
        sh_mode = 1'b1;
      end
    join
    sh_mode = 1'b0;
  endtask

  task automatic test_rewarm_after_reset();
    do_reset();
    pulse_start();
    measure_line(1'b0, 1'b0, "R8");
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    test_warmup_freerun();
    test_idle_after_line();
    test_sh_mode_line();
    test_mode_change_ignored();
    test_rewarm_after_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule